// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo serial audio stream (a bit clock, a word-select line and a data line) and turns it into parallel left and right samples. All three inputs are synchronous to a 256fs master clock. The receiver runs on that master clock. It samples the three lines, finds the bit-clock rising edges and the word-select transitions, and feeds one shared shift register.

Three framings are handled by the same shifter: I2S, MSB-justified and LSB-justified. Each can use a 16-bit or an 18-bit word. A 3-bit format code chooses the framing and the word length. The code comes either from three parallel configuration pins or from a value held in a control register elsewhere, depending on a select input. The receiver latches the code at the word-select transition that opens each word. Every committed word appears on an 18-bit output. 16-bit words are left-aligned in that output. A one-cycle valid pulse marks every right-channel update.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first commit, both sample outputs read zero and the valid output is low.
- R2: Serial data is taken on each rising edge of the bit clock, MSB first. An 18-bit word (format code bit 2 = 1) appears on its output unchanged.
- R3: Framing I2S (code bits [1:0] = 00). The bit taken at the first bit-clock rise after a word-select transition is ignored. The next N bits form the word, and any later bits are ignored. A rising word-select edge commits the word to the right output. A falling edge commits it to the left output.
- R4: Framing MSB-justified (code bits [1:0] = 01). The first N bits after a word-select transition, starting at the first bit-clock rise, form the word. Later bits are ignored. A rising edge commits to the left output and a falling edge commits to the right output.
- R5: Framing LSB-justified (code bits [1:0] = 10). The last N bits taken before the word-select transition form the word, and the final one is the LSB. Earlier bits are ignored. Commit polarity is the same as in R4.
- R6: A 16-bit word (code bit 2 = 0) appears in output bits [17:2], and output bits [1:0] are zero.
- R7: The valid output is high for exactly one master-clock cycle: the cycle in which the right output first shows a newly committed word. A left-channel commit never raises it.
- R8: The right output changes only in a cycle with valid high, and the left output changes only on a left commit.
- R9: When the source select is 1, the format code is taken from the register input and the pin input is ignored. When the select is 0, the opposite holds.
- R10: A word is framed and committed with the format code present at the word-select transition that opened it. A code change that is undone before the next transition has no effect.
- R11: The reserved framing code (bits [1:0] = 11) behaves exactly like I2S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 256fs master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_clk_i | input | 1 | Serial bit clock, synchronous to clk |
| word_sel_i | input | 1 | Left/right word-select line, synchronous to clk |
| ser_data_i | input | 1 | Serial audio data |
| fmt_src_reg_i | input | 1 | 1: format from fmt_reg_i, 0: format from fmt_pin_i |
| fmt_pin_i | input | 3 | Format code from pins: [2] long word, [1:0] framing |
| fmt_reg_i | input | 3 | Format code from control register, same encoding |
| left_o | output | 18 | Last committed left sample, MSB-aligned |
| right_o | output | 18 | Last committed right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle pulse with each right-channel update |

## Verification
The embedded properties check three things on every cycle. The valid output must be a single-cycle pulse that never follows a left commit. The right output may change only together with valid, and the left output may change only on a left commit. Committed 16-bit words must carry zero padding bits, and bit-clock strobes may never be adjacent. The bench's scenarios are needed for the rest: which bits of a word are kept in each framing, the commit polarity per framing, the format-source selection, and a format change that is undone before the next transition having no effect. Filler bits in the stream are driven as ones so that any wrongly kept bit shows up in the sample values.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FRM_I2S  = 2'b00,
    FRM_MSBJ = 2'b01,
    FRM_LSBJ = 2'b10,
    FRM_RSVD = 2'b11
  } frame_e;

  typedef struct packed {
    logic   len_long;
    frame_e frm;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{len_long: 1'b0, frm: FRM_I2S};

  // reserved code is folded into I2S
  function automatic logic is_i2s_like(input frame_e f);
    return (f == FRM_I2S) || (f == FRM_RSVD);
  endfunction

endpackage

// File: rtl/sar_pin_sampler.sv
module sar_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk_i,
  input  logic word_sel_i,
  input  logic ser_data_i,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic lr_lvl_o,
  output logic frm_start_o
);

  logic bck_q, bck_d, lr_q, dat_q, lr_prev_q;
  logic lr_prev_d;

  always_comb begin
    bit_stb_o   = bck_q & ~bck_d;
    bit_val_o   = dat_q;
    lr_lvl_o    = lr_q;
    frm_start_o = bit_stb_o & (lr_q ^ lr_prev_q);
    lr_prev_d   = lr_prev_q;
    if (bit_stb_o) lr_prev_d = lr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q     <= 1'b0;
      bck_d     <= 1'b0;
      lr_q      <= 1'b0;
      dat_q     <= 1'b0;
      lr_prev_q <= 1'b0;
    end else begin
      bck_q     <= bit_clk_i;
      bck_d     <= bck_q;
      lr_q      <= word_sel_i;
      dat_q     <= ser_data_i;
      lr_prev_q <= lr_prev_d;
    end
  end

  AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |=> !bit_stb_o); // R2

endmodule

// File: rtl/sar_word_shifter.sv
module sar_word_shifter
  import sar_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int SHORT_W  = 16,
  parameter int MAX_BITS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              frm_start_i,
  input  fmt_t              fmt_cur_i,
  input  fmt_t              fmt_word_i,
  output logic [DATA_W-1:0] word_o
);

  localparam int CNT_W = $clog2(MAX_BITS + 1);
  localparam int PAD_W = DATA_W - SHORT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BITS);
  localparam logic [CNT_W-1:0] LONG_N  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] SHORT_N = CNT_W'(SHORT_W);

  logic [DATA_W-1:0] sr_q, sr_d, sr_base;
  logic [CNT_W-1:0]  pos_q, pos_d, pos_eff, n_cur;
  logic              keep;

  always_comb begin
    pos_eff = frm_start_i ? '0 : pos_q;
    n_cur   = fmt_cur_i.len_long ? LONG_N : SHORT_N;
    unique case (fmt_cur_i.frm)
      FRM_MSBJ: keep = (pos_eff < n_cur);
      FRM_LSBJ: keep = 1'b1;
      default:  keep = (pos_eff != '0) && (pos_eff <= n_cur);
    endcase
    sr_base = frm_start_i ? '0 : sr_q;
    sr_d    = sr_q;
    pos_d   = pos_q;
    if (bit_stb_i) begin
      sr_d  = keep ? {sr_base[DATA_W-2:0], bit_val_i} : sr_base;
      pos_d = (pos_eff == CNT_MAX) ? pos_eff : pos_eff + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      pos_q <= '0;
    end else begin
      sr_q  <= sr_d;
      pos_q <= pos_d;
    end
  end

  assign word_o = fmt_word_i.len_long ? sr_q
                                      : {sr_q[SHORT_W-1:0], {PAD_W{1'b0}}};

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= CNT_MAX); // R2

  AST_MSBJ_TAIL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb_i && !frm_start_i && fmt_cur_i.frm == FRM_MSBJ && pos_q >= n_cur)
      |=> $stable(sr_q)); // R4

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int SHORT_W  = 16,
  parameter int MAX_BITS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk_i,
  input  logic              word_sel_i,
  input  logic              ser_data_i,
  input  logic              fmt_src_reg_i,
  input  logic [2:0]        fmt_pin_i,
  input  logic [2:0]        fmt_reg_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);

  localparam int PAD_W = DATA_W - SHORT_W;

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic bit_stb, bit_val, lr_lvl, frm_start;

  sar_pin_sampler u_sampler (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .bit_clk_i   (bit_clk_i),
    .word_sel_i  (word_sel_i),
    .ser_data_i  (ser_data_i),
    .bit_stb_o   (bit_stb),
    .bit_val_o   (bit_val),
    .lr_lvl_o    (lr_lvl),
    .frm_start_o (frm_start)
  );

  fmt_t fmt_in, fmt_act_q, fmt_act_d, fmt_cur;
  logic [DATA_W-1:0] word;

  always_comb begin
    fmt_in    = fmt_t'(fmt_src_reg_i ? fmt_reg_i : fmt_pin_i);
    fmt_cur   = frm_start ? fmt_in : fmt_act_q;
    fmt_act_d = frm_start ? fmt_in : fmt_act_q;
  end

  sar_word_shifter #(
    .DATA_W   (DATA_W),
    .SHORT_W  (SHORT_W),
    .MAX_BITS (MAX_BITS)
  ) u_shifter (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .bit_stb_i   (bit_stb),
    .bit_val_i   (bit_val),
    .frm_start_i (frm_start),
    .fmt_cur_i   (fmt_cur),
    .fmt_word_i  (fmt_act_q),
    .word_o      (word)
  );

  logic commit_r, commit_l;
  logic [DATA_W-1:0] left_d, right_d;

  always_comb begin
    commit_r = frm_start & (is_i2s_like(fmt_act_q.frm) ? lr_lvl : ~lr_lvl);
    commit_l = frm_start & ~commit_r;
    left_d   = commit_l ? word : left_o;
    right_d  = commit_r ? word : right_o;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      fmt_act_q <= FMT_RESET;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      fmt_act_q <= fmt_act_d;
      left_o    <= left_d;
      right_o   <= right_d;
      valid_o   <= commit_r;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_o |=> !valid_o); // R7

  AST_NO_VALID_ON_LEFT: assert property (@(posedge clk) disable iff (!rst_s_n)
    commit_l |=> !valid_o); // R7

  AST_RIGHT_MOVES_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(right_o) |-> valid_o); // R8

  AST_LEFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_s_n)
    !commit_l |=> $stable(left_o)); // R8

  AST_SHORT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (commit_r && !fmt_act_q.len_long) |=> (right_o[PAD_W-1:0] == '0)); // R6

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bck = 1'b0, wsel = 1'b0, sdat = 1'b0;
  logic        src_reg = 1'b0;
  logic [2:0]  fpin = 3'd0, freg = 3'd7;
  logic [17:0] left_o, right_o;
  logic        valid_o;

  serial_audio_rx u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_clk_i     (bck),
    .word_sel_i    (wsel),
    .ser_data_i    (sdat),
    .fmt_src_reg_i (src_reg),
    .fmt_pin_i     (fpin),
    .fmt_reg_i     (freg),
    .left_o        (left_o),
    .right_o       (right_o),
    .valid_o       (valid_o)
  );

  typedef struct {
    logic [17:0] l;
    logic [17:0] r;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0;
  logic [17:0] m_l = '0, m_r = '0, pend = '0;
  logic [2:0]  pend_code = 3'd0;
  string       pend_tag = "R1";
  logic        prev_lvl = 1'b0;
  bit          done = 0;

  task automatic chk(string tag, string what, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [17:0] align(logic [17:0] w, logic [2:0] code);
    return code[2] ? w : {w[15:0], 2'b00};
  endfunction

  function automatic logic i2s_like(logic [2:0] code);
    return (code[1:0] == 2'b00) || (code[1:0] == 2'b11);
  endfunction

  // the unused source carries the complement as a decoy (R9)
  task automatic set_code(logic [2:0] c);
    if (src_reg) begin freg = c; fpin = ~c; end
    else         begin fpin = c; freg = ~c; end
  endtask

  task automatic send_half(logic lvl, logic [17:0] w, logic [2:0] code,
                           string tag, bit poke);
    int  n;
    logic b;
    set_code(code);
    if (lvl != prev_lvl) begin
      if (i2s_like(pend_code) ? lvl : !lvl) begin
        m_r = pend;
        sb.push_back('{l: m_l, r: m_r, tag: pend_tag});
      end else begin
        m_l = pend;
      end
    end
    n = code[2] ? 18 : 16;
    for (int p = 0; p < 32; p++) begin
      unique case (code[1:0])
        2'b01:   b = (p < n) ? w[n-1-p] : 1'b1;
        2'b10:   b = (p >= 32 - n) ? w[31-p] : 1'b1;
        default: b = (p >= 1 && p <= n) ? w[n-p] : 1'b1;
      endcase
      bck  = 1'b0;
      wsel = lvl;
      sdat = b;
      if (poke && p == 10) set_code(code ^ 3'b101); // R10 transient change
      if (poke && p == 20) set_code(code);
      @(negedge clk);
      @(negedge clk);
      bck = 1'b1;
      @(negedge clk);
      @(negedge clk);
    end
    pend      = align(w, code);
    pend_code = code;
    pend_tag  = tag;
    prev_lvl  = lvl;
  endtask

  function automatic string tag_of(logic [2:0] code);
    string base;
    unique case (code[1:0])
      2'b00: base = "R3";
      2'b01: base = "R4";
      2'b10: base = "R5";
      default: base = "R11";
    endcase
    return {base, code[2] ? "/R2" : "/R6"};
  endfunction

  // monitor: pops the scoreboard on each valid pulse
  logic        v_prev = 1'b0;
  logic [17:0] r_prev = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        n_chk++;
        if (v_prev) begin
          n_bad++;
          $display("FAIL R7 valid width actual=2+ expected=1");
        end
        if (sb.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R7 unexpected valid actual=%h expected=none", right_o);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.tag, "right", right_o, e.r);
          chk(e.tag, "left",  left_o,  e.l);
        end
      end else if (right_o !== r_prev) begin
        n_chk++; n_bad++;
        $display("FAIL R8 right changed without valid actual=%h expected=%h", right_o, r_prev);
      end
      v_prev <= valid_o;
      r_prev <= right_o;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int k = 0;
    logic [17:0] w;
    logic [2:0] codes[8] = '{3'd0, 3'd4, 3'd1, 3'd5, 3'd2, 3'd6, 3'd3, 3'd7};
    repeat (5) @(negedge clk);
    chk("R1", "left in reset",  left_o,  '0);
    chk("R1", "right in reset", right_o, '0);
    chk("R1", "valid in reset", {17'd0, valid_o}, '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "left after reset",  left_o,  '0);
    chk("R1", "valid after reset", {17'd0, valid_o}, '0);

    // first half keeps the reset format (I2S, 16-bit), no transition
    send_half(1'b0, 18'h0A5F1, 3'd0, "R3/R6", 0);

    foreach (codes[i]) begin
      for (int h = 0; h < 4; h++) begin
        k++;
        w = 18'((k * 18'h1F3A7) ^ 18'h2C55A);
        if (k % 5 == 0) w = '0;
        if (k % 7 == 0) w = '1;
        send_half(~prev_lvl, w, codes[i], tag_of(codes[i]), 0);
      end
    end

    // format from the register input, pins carry a decoy
    src_reg = 1'b1;
    foreach (codes[i]) begin
      k++;
      w = 18'((k * 18'h0B3D9) ^ 18'h15A3C);
      send_half(~prev_lvl, w, codes[i], "R9", 0);
      send_half(~prev_lvl, ~w, codes[i], "R9", 0);
    end
    src_reg = 1'b0;

    // transient code change inside a word must not matter
    for (int h = 0; h < 4; h++) begin
      k++;
      w = 18'((k * 18'h2468B) ^ 18'h31F0E);
      send_half(~prev_lvl, w, (h % 2) ? 3'd1 : 3'd5, "R10", 1);
    end

    // flush: two more transitions commit the pending words
    send_half(~prev_lvl, 18'h00000, 3'd0, "R3/R6", 0);
    send_half(~prev_lvl, 18'h00000, 3'd0, "R3/R6", 0);
    repeat (10) @(negedge clk);

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R7 pending items actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule